// File: doc/BRIEF.md
# Iterative Feistel Block Cipher Core

This block encrypts or decrypts one 64-bit word at a time with a 64-bit key, using a two-half Feistel network that completes one round per clock. A single start pulse captures the data word, the key and the direction. The core then iterates fourteen rounds on two 32-bit halves and presents the result on a registered output together with a one-cycle completion pulse.

Every round first mixes a 32-bit subkey into the left half. It then passes that half through eight copies of one 4-bit substitution box, rotates the 32-bit result, and folds it into the right half before the halves trade places. Sixteen subkeys come from the key by XOR with fixed constants. Fourteen of them feed the rounds and the last two whiten the output. Decryption uses the same datapath with the subkey order reversed.

Top module: `feistel_lw_cipher`

## Requirements
- R1: While `rst` is high at a rising edge, the core clears `busy`, `done` and `data_out` to zero; after reset they read zero until a start is accepted.
- R2: A `start` sampled high while `busy` is low is accepted. `busy` is high from the next edge until the edge that sets `done`. `done` rises on the 15th rising edge, counting the edge that sampled `start` as the first.
- R3: `done` is high for exactly one clock cycle per accepted operation.
- R4: `data_out` changes only on the edge that raises `done` (or on reset), and holds its value while inputs other than `start` toggle.
- R5: A `start` pulse while `busy` is high is ignored: the running operation's result is unchanged, and no second operation follows.
- R6: The round function replaces each of the eight 4-bit nibbles of its 32-bit input with S(x), where S maps 0..F to E,7,8,4,1,9,2,F,5,A,B,0,6,C,D,3. It then rotates the 32-bit word left by 7 bits.
- R7: The subkeys are P[i] = C[i] XOR H, for i = 0..15. C[i] = (i+1) * 0x9E3779B9 modulo 2^32. H is `key_in[63:32]` for even i and `key_in[31:0]` for odd i.
- R8: Encryption takes L = `data_in[63:32]` and R = `data_in[31:0]`. For j = 0..13 it performs L ^= P[j]; R ^= F(L); swap L and R. It then undoes the last swap, applies R ^= P[14] and L ^= P[15], and outputs `data_out` = {L, R}.
- R9: With `decrypt` high at start, the same procedure runs with P[15-j] in place of P[j]. As a result, decrypting an encryption under the same key returns the original word.
- R10: `key_in`, `data_in` and `decrypt` are captured at the accepted start; changing them while `busy` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation when idle |
| decrypt | input | 1 | High selects decryption, low encryption |
| key_in | input | 64 | Cipher key |
| data_in | input | 64 | Plaintext or ciphertext word |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle completion pulse |
| data_out | output | 64 | Registered result |

## Verification
Encryption is compared against an independent model for an all-zero word and key, an all-ones word and key, alternating bit patterns, and pseudo-random words under keys whose two halves differ. The zero cases expose the constants and the S-box directly. The asymmetric keys tell apart the even and odd subkey halves and the whitening order. Decryption is checked both against the model and as a round trip, which separates a correct reversal of the subkey order from one that is merely self-consistent. Separate runs disturb the inputs and pulse `start` mid-operation to show that captured state and the busy guard isolate the running computation.

// File: rtl/flc_pkg.sv
package flc_pkg;

  localparam logic [31:0] GOLDEN = 32'h9E3779B9;

  function automatic logic [3:0] sbox4(input logic [3:0] x);
    logic [3:0] y;
    case (x)
      4'h0: y = 4'hE;
      4'h1: y = 4'h7;
      4'h2: y = 4'h8;
      4'h3: y = 4'h4;
      4'h4: y = 4'h1;
      4'h5: y = 4'h9;
      4'h6: y = 4'h2;
      4'h7: y = 4'hF;
      4'h8: y = 4'h5;
      4'h9: y = 4'hA;
      4'hA: y = 4'hB;
      4'hB: y = 4'h0;
      4'hC: y = 4'h6;
      4'hD: y = 4'hC;
      4'hE: y = 4'hD;
      default: y = 4'h3;
    endcase
    return y;
  endfunction

  function automatic logic [31:0] round_const(input int idx);
    logic [31:0] mult;
    mult = 32'(idx + 1);
    return GOLDEN * mult;
  endfunction

endpackage

// File: rtl/flc_keysched.sv
module flc_keysched #(
  parameter int HALF_W = 32,
  parameter int NKEYS  = 16
) (
  input  logic [2*HALF_W-1:0]           key,
  output logic [NKEYS-1:0][HALF_W-1:0]  subkeys
);
  logic [HALF_W-1:0] key_hi;
  logic [HALF_W-1:0] key_lo;

  assign key_hi = key[2*HALF_W-1:HALF_W];
  assign key_lo = key[HALF_W-1:0];

  // R7: even entries use the upper key half, odd entries the lower
  for (genvar i = 0; i < NKEYS; i++) begin : g_sub
    localparam logic [31:0] CI = flc_pkg::round_const(i);
    if ((i % 2) == 0) begin : g_even
      assign subkeys[i] = HALF_W'(CI) ^ key_hi;
    end else begin : g_odd
      assign subkeys[i] = HALF_W'(CI) ^ key_lo;
    end
  end
endmodule

// File: rtl/flc_sbox_layer.sv
module flc_sbox_layer #(
  parameter int HALF_W = 32
) (
  input  logic [HALF_W-1:0] din,
  output logic [HALF_W-1:0] dout
);
  localparam int NIB = HALF_W / 4;

  // R6: one 4-bit box per nibble, all identical
  for (genvar n = 0; n < NIB; n++) begin : g_box
    assign dout[4*n +: 4] = flc_pkg::sbox4(din[4*n +: 4]);
  end
endmodule

// File: rtl/flc_round.sv
module flc_round #(
  parameter int HALF_W = 32,
  parameter int ROT    = 7
) (
  input  logic [HALF_W-1:0] left_in,
  input  logic [HALF_W-1:0] right_in,
  input  logic [HALF_W-1:0] subkey,
  output logic [HALF_W-1:0] left_keyed,
  output logic [HALF_W-1:0] right_mixed
);
  logic [HALF_W-1:0] subst;
  logic [HALF_W-1:0] rotated;

  assign left_keyed = left_in ^ subkey;

  flc_sbox_layer #(.HALF_W(HALF_W)) u_sbox (
    .din  (left_keyed),
    .dout (subst)
  );

  assign rotated     = {subst[HALF_W-ROT-1:0], subst[HALF_W-1:HALF_W-ROT]};
  assign right_mixed = right_in ^ rotated;
endmodule

// File: rtl/feistel_lw_cipher.sv
module feistel_lw_cipher #(
  parameter int HALF_W = 32,
  parameter int ROUNDS = 14,
  parameter int ROT    = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  decrypt,
  input  logic [2*HALF_W-1:0]   key_in,
  input  logic [2*HALF_W-1:0]   data_in,
  output logic                  busy,
  output logic                  done,
  output logic [2*HALF_W-1:0]   data_out
);
  localparam int NKEYS  = ROUNDS + 2;
  localparam int CNT_W  = $clog2(ROUNDS);
  localparam int KIDX_W = $clog2(NKEYS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS - 1);

  logic [HALF_W-1:0]          left_q, right_q;
  logic [2*HALF_W-1:0]        key_q;
  logic                       dec_q;
  logic [CNT_W-1:0]           cnt_q;
  logic                       busy_q, done_q;
  logic [2*HALF_W-1:0]        out_q;

  logic [NKEYS-1:0][HALF_W-1:0] subkeys;
  logic [KIDX_W-1:0]            kidx;
  logic [HALF_W-1:0]            rkey, white_r, white_l;
  logic [HALF_W-1:0]            a_keyed, b_mixed;

  flc_keysched #(.HALF_W(HALF_W), .NKEYS(NKEYS)) u_keys (
    .key     (key_q),
    .subkeys (subkeys)
  );

  // R9: decryption walks the subkey array from the top down
  always_comb begin
    if (dec_q) begin
      kidx    = KIDX_W'(NKEYS - 1) - KIDX_W'(cnt_q);
      white_r = subkeys[1];
      white_l = subkeys[0];
    end else begin
      kidx    = KIDX_W'(cnt_q);
      white_r = subkeys[NKEYS-2];
      white_l = subkeys[NKEYS-1];
    end
    rkey = subkeys[kidx];
  end

  flc_round #(.HALF_W(HALF_W), .ROT(ROT)) u_round (
    .left_in     (left_q),
    .right_in    (right_q),
    .subkey      (rkey),
    .left_keyed  (a_keyed),
    .right_mixed (b_mixed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      right_q <= '0;
      key_q   <= '0;
      dec_q   <= 1'b0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      out_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          left_q  <= data_in[2*HALF_W-1:HALF_W];
          right_q <= data_in[HALF_W-1:0];
          key_q   <= key_in;
          dec_q   <= decrypt;
          cnt_q   <= '0;
          busy_q  <= 1'b1;
        end
      end else if (cnt_q == LAST) begin
        // R8: last round leaves halves unswapped, then whitening
        out_q  <= {a_keyed ^ white_l, b_mixed ^ white_r};
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        left_q  <= b_mixed;
        right_q <= a_keyed;
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign data_out = out_q;

  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r2_busy_continues: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt_q != LAST) |=> (busy && !done));

  a_r2_finish_edge: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt_q == LAST) |=> (!busy && done));

  a_r4_out_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(data_out) || $past(rst));

  a_r5_no_restart: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(key_q) && $stable(dec_q));

  a_r2_start_accept: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && cnt_q == '0));

endmodule

// File: tb/feistel_lw_cipher_test.sv
`timescale 1ns/1ps
module feistel_lw_cipher_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic        decrypt;
  logic [63:0] key_in;
  logic [63:0] data_in;
  logic        busy;
  logic        done;
  logic [63:0] data_out;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  feistel_lw_cipher uut (
    .clk(clk), .rst(rst), .start(start), .decrypt(decrypt),
    .key_in(key_in), .data_in(data_in),
    .busy(busy), .done(done), .data_out(data_out)
  );

  // ---------------- reference model from the requirements ----------------
  localparam logic [63:0] SBOX_NIB = 64'h3DC60BA5F291487E;

  function automatic logic [31:0] ref_f(input logic [31:0] x);
    logic [31:0] s;
    for (int n = 0; n < 8; n++) s[4*n +: 4] = SBOX_NIB[4*x[4*n +: 4] +: 4];
    return (s << 7) | (s >> 25);
  endfunction

  function automatic logic [31:0] ref_p(input logic [63:0] k, input int i);
    logic [31:0] c;
    logic [31:0] m;
    m = 32'(i + 1);
    c = 32'h9E3779B9 * m;
    return c ^ (((i % 2) == 0) ? k[63:32] : k[31:0]);
  endfunction

  function automatic logic [63:0] ref_run(input logic dec, input logic [63:0] k,
                                          input logic [63:0] d);
    logic [31:0] l, r, t;
    int idx;
    l = d[63:32];
    r = d[31:0];
    for (int j = 0; j < 14; j++) begin
      idx = dec ? 15 - j : j;
      l = l ^ ref_p(k, idx);
      r = r ^ ref_f(l);
      t = l; l = r; r = t;
    end
    t = l; l = r; r = t;
    r = r ^ ref_p(k, dec ? 1 : 14);
    l = l ^ ref_p(k, dec ? 0 : 15);
    return {l, r};
  endfunction

  // ---------------- check helpers ----------------
  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One operation; disturb: 0 none, 1 start pulse mid-run, 2 inputs change mid-run
  task automatic do_op(input logic dec, input logic [63:0] k, input logic [63:0] d,
                       input int disturb, output logic [63:0] res, output int lat);
    @(negedge clk);
    decrypt = dec; key_in = k; data_in = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      if (disturb == 1 && lat == 5) begin
        start = 1'b1; data_in = ~d; decrypt = ~dec;
      end else if (disturb == 1 && lat == 6) begin
        start = 1'b0;
      end
      if (disturb == 2 && lat == 3) begin
        key_in = ~k; data_in = d ^ 64'h5555_0000_AAAA_FFFF; decrypt = ~dec;
      end
      @(negedge clk);
      lat++;
    end
    res = data_out;
    @(negedge clk);
    chk("R3 done width", {63'd0, done}, 64'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1; start = 1'b0; decrypt = 1'b0; key_in = '0; data_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy", {63'd0, busy}, 64'd0);
    chk("R1 done", {63'd0, done}, 64'd0);
    chk("R1 data_out", data_out, 64'd0);
  endtask

  task automatic t_encrypt_patterns();
    logic [63:0] res, k, d;
    int lat;
    logic [63:0] keys [5];
    logic [63:0] dats [5];
    keys[0] = 64'h0; dats[0] = 64'h0;
    keys[1] = '1;    dats[1] = '1;
    keys[2] = 64'hAAAA_AAAA_5555_5555; dats[2] = 64'h5555_5555_AAAA_AAAA;
    keys[3] = 64'h0123_4567_89AB_CDEF; dats[3] = 64'h0000_0000_0000_0001;
    keys[4] = 64'hFEDC_0000_0000_1234; dats[4] = 64'h8000_0000_0000_0000;
    for (int i = 0; i < 5; i++) begin
      k = keys[i]; d = dats[i];
      do_op(1'b0, k, d, 0, res, lat);
      chk("R6 R7 R8 encrypt", res, ref_run(1'b0, k, d));
      chk("R2 latency", 64'(lat), 64'd15);
    end
  endtask

  task automatic t_random_roundtrip();
    logic [63:0] lfsr, k, d, ct, pt;
    int lat;
    lfsr = 64'hC0FF_EE12_3456_789B;
    for (int i = 0; i < 6; i++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      k = lfsr * 64'd6364136223846793005;
      d = lfsr ^ {lfsr[31:0], lfsr[63:32]};
      do_op(1'b0, k, d, 0, ct, lat);
      chk("R8 random encrypt", ct, ref_run(1'b0, k, d));
      do_op(1'b1, k, ct, 0, pt, lat);
      chk("R9 decrypt model", pt, ref_run(1'b1, k, ct));
      chk("R9 round trip", pt, d);
    end
  endtask

  task automatic t_start_while_busy();
    logic [63:0] res, k, d;
    int lat;
    k = 64'h1111_2222_3333_4444; d = 64'hDEAD_BEEF_0BAD_F00D;
    do_op(1'b0, k, d, 1, res, lat);
    chk("R5 result kept", res, ref_run(1'b0, k, d));
    chk("R5 latency kept", 64'(lat), 64'd15);
    repeat (3) @(negedge clk);
    chk("R5 no second run", {63'd0, busy}, 64'd0);
  endtask

  task automatic t_inputs_change();
    logic [63:0] res, k, d;
    int lat;
    k = 64'h0F0F_1234_F0F0_4321; d = 64'h7766_5544_3322_1100;
    do_op(1'b1, k, d, 2, res, lat);
    chk("R10 captured inputs", res, ref_run(1'b1, k, d));
  endtask

  task automatic t_hold();
    logic [63:0] res, held;
    int lat;
    do_op(1'b0, 64'h2468_ACE0_1357_9BDF, 64'h0, 0, res, lat);
    held = data_out;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      key_in = key_in + 64'd3; data_in = ~data_in; decrypt = ~decrypt;
    end
    @(negedge clk);
    chk("R4 output hold", data_out, held);
    chk("R4 no done", {63'd0, done}, 64'd0);
  endtask

  initial begin
    t_reset();
    t_encrypt_patterns();
    t_random_roundtrip();
    t_start_while_busy();
    t_inputs_change();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule